// File: doc/BRIEF.md
# Pin Input Deglitch Filter

This block cleans up one general-purpose input pin before its level is used as readable pin status and as the source for interrupt detection. The raw pin is first brought into the core clock domain by a short synchronizer chain. A filter state machine then decides when the clean output may follow the synchronized level. The decision is timed against a slow always-on tick of about 32.8 kHz, which arrives as a one-cycle strobe in the core clock domain.

Three per-pin configuration fields control the filter. A mode field chooses between no filtering, qualification of both edges, or one of two asymmetric policies in which edges toward one level pass at once and edges toward the other level must prove stable. A timebase field sets how many slow ticks make one count step. A stability field sets how many steps the new level must hold. Each time filtering is switched on from the off mode, the block runs a warm-up period. During warm-up a software interrupt-enable request is hidden from the readback, so driver code that polls the enable bit waits until the filter has settled.

Filter states: `F_PASS` (no filtering, output copies the synchronized level), `F_HOLD` (filtering, output steady), `F_QUAL` (filtering, new level being timed). Transitions: any state goes to `F_PASS` when the mode is off. `F_PASS` goes to `F_HOLD` when a filtering mode is selected. `F_HOLD` goes to `F_QUAL` when the input differs from the output and that direction must be qualified. `F_QUAL` goes back to `F_HOLD` either when the input returns to the output level (a bounce) or when the final step completes (the output then takes the new level). Warm-up states: `W_OFF` goes to `W_RUN` when a filtering mode is selected, `W_RUN` goes to `W_DONE` after the last warm-up tick, and any state goes to `W_OFF` when the mode is off.

Top module: `pin_deglitch`

## Requirements
- R1: With the mode set to off, `pin_level` equals `pin_raw` delayed by exactly three clock edges: two synchronizer edges plus one output register edge.
- R2: The mode field encodes 0 = off, 1 = qualify both edges, 2 = keep low glitches, 3 = keep high glitches.
- R3: In mode 1, `pin_level` takes a new level only after the synchronized input has differed from it for N steps of L ticks. If the input returns to the output level before that, the count restarts from zero.
- R4: The timebase field sets the step length L to 2, 8, 512 or 2048 slow ticks for the values 0, 1, 2 and 3.
- R5: The stability field gives the step count N (0 to 15). A value of 0 acts as N = 1.
- R6: In mode 2, a falling edge reaches `pin_level` on the edge after the synchronizer, three edges after the pin changes. A rising edge must pass the N×L qualification.
- R7: In mode 3, a rising edge passes through in three edges. A falling edge must pass the N×L qualification.
- R8: Step and warm-up counting advance only in cycles where `slow_tick` is 1.
- R9: After the mode changes from off to any filtering mode, `filt_ready` and `irq_en_rdbk` stay 0 until WARM_TICKS slow ticks have passed, whatever `irq_en_req` is. After that, `irq_en_rdbk` equals `irq_en_req`.
- R10: With the mode off, `irq_en_rdbk` equals `irq_en_req` in the same cycle.
- R11: While reset is held, `pin_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow always-on tick |
| pin_raw | input | 1 | Asynchronous raw pin level |
| filt_mode | input | 2 | Filter policy: 0 off, 1 both, 2 keep-low, 3 keep-high |
| tbase_sel | input | 2 | Ticks per step: 2, 8, 512, 2048 |
| stab_count | input | 4 | Steps the new level must hold (0 acts as 1) |
| irq_en_req | input | 1 | Interrupt enable as written by software |
| pin_level | output | 1 | Filtered pin level |
| filt_ready | output | 1 | High when the filter is off or warm-up is complete |
| irq_en_rdbk | output | 1 | Interrupt enable as read back, gated by warm-up |

## Verification
If the filter state machine is left in `F_QUAL` with a stale count, the output changes too early or too late against an N×L window that is known exactly. These errors appear at the first qualified edge, within a few clocks of the expected edge, so the bench samples just before and just after that edge. A stuck warm-up state shows up on `irq_en_rdbk` at the tick where warm-up should end, or right away if readback is gated while the mode is off. A bad synchronizer depth shifts the pass-through and fast-edge timing by whole clocks, and the three-edge checks catch this.

// File: rtl/pin_deglitch_pkg.sv
package pin_deglitch_pkg;

    typedef enum logic [1:0] {
        FM_OFF     = 2'd0,
        FM_BOTH    = 2'd1,
        FM_KEEP_LO = 2'd2,
        FM_KEEP_HI = 2'd3
    } fmode_t;

    typedef enum logic [1:0] {
        F_PASS = 2'd0,
        F_HOLD = 2'd1,
        F_QUAL = 2'd2
    } fstate_t;

    typedef enum logic [1:0] {
        W_OFF  = 2'd0,
        W_RUN  = 2'd1,
        W_DONE = 2'd2
    } wstate_t;

endpackage

// File: rtl/pdg_sync.sv
module pdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pdg_stepper.sv
module pdg_stepper #(
    parameter int STEP_A = 2,
    parameter int STEP_B = 8,
    parameter int STEP_C = 512,
    parameter int STEP_D = 2048,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [1:0]       tbase_i,
    input  logic [CNT_W-1:0] stab_i,
    output logic             done_o
);
    localparam int MAX_AB  = (STEP_A > STEP_B) ? STEP_A : STEP_B;
    localparam int MAX_CD  = (STEP_C > STEP_D) ? STEP_C : STEP_D;
    localparam int MAX_ST  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int PRESC_W = $clog2(MAX_ST);

    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   steps;
    logic [PRESC_W-1:0] len_m1;
    logic [CNT_W-1:0]   tgt_m1;
    logic               step_end;

    always_comb begin
        unique case (tbase_i)
            2'd0:    len_m1 = PRESC_W'(STEP_A - 1);
            2'd1:    len_m1 = PRESC_W'(STEP_B - 1);
            2'd2:    len_m1 = PRESC_W'(STEP_C - 1);
            default: len_m1 = PRESC_W'(STEP_D - 1);
        endcase
    end

    assign tgt_m1   = (stab_i == '0) ? '0 : stab_i - 1'b1;
    assign step_end = tick_i && (presc >= len_m1);
    assign done_o   = step_end && (steps >= tgt_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            steps <= '0;
        end else if (clear_i) begin
            presc <= '0;
            steps <= '0;
        end else if (step_end) begin
            presc <= '0;
            steps <= steps + 1'b1;
        end else if (tick_i) begin
            presc <= presc + 1'b1;
        end
    end

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> ($stable(presc) && $stable(steps)));
endmodule

// File: rtl/pdg_warmup.sv
module pdg_warmup
    import pin_deglitch_pkg::*;
#(
    parameter int WARM_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic ready_o
);
    localparam int WARM_W = $clog2(WARM_TICKS + 1);

    wstate_t           wst, wnxt;
    logic [WARM_W-1:0] wcnt;
    logic              last_tick;

    assign last_tick = tick_i && (wcnt == WARM_W'(WARM_TICKS - 1));

    always_comb begin
        wnxt = wst;
        unique case (wst)
            W_OFF:   wnxt = en_i ? W_RUN : W_OFF;
            W_RUN:   wnxt = !en_i ? W_OFF : (last_tick ? W_DONE : W_RUN);
            W_DONE:  wnxt = en_i ? W_DONE : W_OFF;
            default: wnxt = W_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wst <= W_OFF;
        else        wst <= wnxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         wcnt <= '0;
        else if (wst != W_RUN)              wcnt <= '0;
        else if (tick_i && !last_tick)      wcnt <= wcnt + 1'b1;
    end

    assign ready_o = !en_i || (wst == W_DONE);

    assert_run_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wst == W_RUN && en_i && !tick_i) |=> (wst == W_RUN));
endmodule

// File: rtl/pdg_filter_fsm.sv
module pdg_filter_fsm
    import pin_deglitch_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  fmode_t mode_i,
    input  logic   sync_i,
    input  logic   done_i,
    output logic   clear_o,
    output logic   level_o
);
    fstate_t fst, fnxt;
    logic    lvl_q;
    logic    off, diff, fast;

    assign off  = (mode_i == FM_OFF);
    assign diff = (sync_i != lvl_q);
    assign fast = (mode_i == FM_KEEP_LO && !sync_i) ||
                  (mode_i == FM_KEEP_HI &&  sync_i);

    always_comb begin
        fnxt = fst;
        unique case (fst)
            F_PASS:  fnxt = off ? F_PASS : F_HOLD;
            F_HOLD:  fnxt = off ? F_PASS : ((diff && !fast) ? F_QUAL : F_HOLD);
            F_QUAL:  fnxt = off ? F_PASS : ((!diff || done_i) ? F_HOLD : F_QUAL);
            default: fnxt = F_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fst <= F_PASS;
        else        fst <= fnxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            unique case (fst)
                F_PASS:  lvl_q <= sync_i;
                F_HOLD:  if (!off && diff && fast) lvl_q <= sync_i;
                F_QUAL:  if (!off && diff && done_i) lvl_q <= sync_i;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    assign clear_o = (fst != F_QUAL);
    assign level_o = lvl_q;

    assert_wait_in_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_QUAL && !off && diff && !done_i) |=> $stable(lvl_q));
    assert_fast_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_HOLD && mode_i == FM_KEEP_LO && !sync_i && lvl_q) |=> !lvl_q);
    assert_fast_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == F_HOLD && mode_i == FM_KEEP_HI && sync_i && !lvl_q) |=> lvl_q);
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
    import pin_deglitch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STEP_A      = 2,
    parameter int STEP_B      = 8,
    parameter int STEP_C      = 512,
    parameter int STEP_D      = 2048,
    parameter int STAB_W      = 4,
    parameter int WARM_TICKS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              pin_raw,
    input  logic [1:0]        filt_mode,
    input  logic [1:0]        tbase_sel,
    input  logic [STAB_W-1:0] stab_count,
    input  logic              irq_en_req,
    output logic              pin_level,
    output logic              filt_ready,
    output logic              irq_en_rdbk
);
    fmode_t mode;
    logic   pin_sync, step_done, step_clear;

    assign mode = fmode_t'(filt_mode);

    pdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(pin_sync)
    );

    pdg_stepper #(
        .STEP_A(STEP_A), .STEP_B(STEP_B), .STEP_C(STEP_C), .STEP_D(STEP_D),
        .CNT_W(STAB_W)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .clear_i(step_clear), .tick_i(slow_tick),
        .tbase_i(tbase_sel), .stab_i(stab_count), .done_o(step_done)
    );

    pdg_filter_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sync_i(pin_sync),
        .done_i(step_done), .clear_o(step_clear), .level_o(pin_level)
    );

    pdg_warmup #(.WARM_TICKS(WARM_TICKS)) u_warm (
        .clk(clk), .rst_n(rst_n), .en_i(mode != FM_OFF), .tick_i(slow_tick),
        .ready_o(filt_ready)
    );

    assign irq_en_rdbk = irq_en_req && filt_ready;

    assert_pass_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FM_OFF && $past(mode) == FM_OFF && $past(mode, 2) == FM_OFF)
        |-> (pin_level == $past(pin_sync)));
    assert_off_rdbk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FM_OFF) |-> (irq_en_rdbk == irq_en_req));
    assert_rdbk_implies_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_rdbk |-> irq_en_req);
endmodule

// File: tb/pin_deglitch_bench.sv
module pin_deglitch_bench;
    localparam int WARM = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b1;
    logic       pin_raw = 1'b0;
    logic [1:0] filt_mode = 2'd0;
    logic [1:0] tbase_sel = 2'd0;
    logic [3:0] stab_count = 4'd0;
    logic       irq_en_req = 1'b0;
    logic       pin_level, filt_ready, irq_en_rdbk;

    int n_chk = 0;
    int n_bad = 0;

    pin_deglitch #(.WARM_TICKS(WARM)) u_pin_deglitch (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pin_raw(pin_raw),
        .filt_mode(filt_mode), .tbase_sel(tbase_sel), .stab_count(stab_count),
        .irq_en_req(irq_en_req), .pin_level(pin_level), .filt_ready(filt_ready),
        .irq_en_rdbk(irq_en_rdbk)
    );

    always #4 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive a level that must be qualified for nl clock edges (tick every cycle)
    task automatic qual_edge(input string tag, input logic v, input int nl);
        pin_raw = v;
        step(nl);
        chk(tag, pin_level, !v);
        step(4);
        chk(tag, pin_level, v);
    endtask

    task automatic fast_edge(input string tag, input logic v);
        pin_raw = v;
        step(2);
        chk(tag, pin_level, !v);
        step(1);
        chk(tag, pin_level, v);
    endtask

    task automatic t_reset;
        #1;
        chk("R11 reset level", pin_level, 1'b0);
        step(3);
        chk("R11 reset level held", pin_level, 1'b0);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic t_pass;
        irq_en_req = 1'b1;
        #1;
        chk("R10 off rdbk follows req", irq_en_rdbk, 1'b1);
        fast_edge("R1 pass rise", 1'b1);
        fast_edge("R1 pass fall", 1'b0);
        irq_en_req = 1'b0;
        #1;
        chk("R10 off rdbk drop", irq_en_rdbk, 1'b0);
    endtask

    task automatic t_warm;
        irq_en_req = 1'b1;
        filt_mode = 2'd1; tbase_sel = 2'd0; stab_count = 4'd4;
        #1;
        chk("R9 rdbk gated at enable", irq_en_rdbk, 1'b0);
        step(WARM - 1);
        chk("R9 still warming", irq_en_rdbk, 1'b0);
        chk("R9 ready low", filt_ready, 1'b0);
        step(2);
        chk("R9 rdbk after warm", irq_en_rdbk, 1'b1);
        irq_en_req = 1'b0;
        #1;
        chk("R9 rdbk follows req", irq_en_rdbk, 1'b0);
    endtask

    task automatic t_both;
        qual_edge("R3 R2 both rise", 1'b1, 8);
        pin_raw = 1'b0; step(5);
        pin_raw = 1'b1; step(2);
        pin_raw = 1'b0;
        step(8);
        chk("R3 bounce restarts", pin_level, 1'b1);
        step(4);
        chk("R3 settle after bounce", pin_level, 1'b0);
    endtask

    task automatic t_timebase;
        tbase_sel = 2'd1; stab_count = 4'd2;
        qual_edge("R4 base8", 1'b1, 16);
        tbase_sel = 2'd2; stab_count = 4'd1;
        qual_edge("R4 base512", 1'b0, 512);
        tbase_sel = 2'd3; stab_count = 4'd1;
        qual_edge("R4 base2048", 1'b1, 2048);
        tbase_sel = 2'd0; stab_count = 4'd0;
        qual_edge("R5 zero count", 1'b0, 2);
    endtask

    task automatic t_keep;
        stab_count = 4'd4;
        filt_mode = 2'd2;
        qual_edge("R6 keep-low rise qualified", 1'b1, 8);
        fast_edge("R6 keep-low fall fast", 1'b0);
        filt_mode = 2'd3;
        fast_edge("R7 keep-high rise fast", 1'b1);
        qual_edge("R7 keep-high fall qualified", 1'b0, 8);
    endtask

    task automatic t_tick;
        filt_mode = 2'd1;
        slow_tick = 1'b0;
        pin_raw = 1'b1;
        step(100);
        chk("R8 no tick no change", pin_level, 1'b0);
        slow_tick = 1'b1;
        step(6);
        chk("R8 counting resumed early", pin_level, 1'b0);
        step(4);
        chk("R8 counting resumed done", pin_level, 1'b1);
    endtask

    initial begin
        t_reset;
        t_pass;
        t_warm;
        t_both;
        t_timebase;
        t_keep;
        t_tick;
        filt_mode = 2'd0;
        irq_en_req = 1'b1;
        #1;
        chk("R10 off again rdbk", irq_en_rdbk, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule